// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver with Break Detection

The block recovers bytes from an asynchronous serial line that idles high. It waits for the high-to-low transition that opens a character. It then places its first sample near the middle of the start bit and samples every following bit one bit period later: eight data bits, least significant first, then one stop bit. The bit period is set in clock cycles through an input. A second input shortens the delay to the first sample, so that the latency of the input path is offset and the samples stay centred.

Each finished character is delivered with a one-cycle strobe. A low stop bit marks the character as badly framed. A badly framed character whose data bits are all zero is reported as a line break. The receiver is idle again as soon as it has taken the stop-bit sample. This lets it follow traffic that has only one stop bit between characters. A short low pulse that has ended by the first sample point is treated as noise and dropped.

Top module: `uart_rx_brk`

## Requirements
- R1: The serial input passes through a two-stage synchroniser. While idle, a high-to-low transition of the synchronised line starts a character. A line held low does not start a new character.
- R2: The first sample is taken D = max(1, floor(P/2) − C) clock cycles after the falling edge is detected. P is `clks_per_bit_i` and must be at least 4. C is `lat_comp_i`. Each later sample follows P cycles after the previous one. From the clock edge that first captures the falling input, `valid_o` is high (D + 2 + 9·P) cycles later.
- R3: The eight data bits arrive least significant bit first. Bit 0 of `data_o` is the first bit after the start bit.
- R4: `valid_o` is high for exactly one clock cycle per character, together with the new `data_o`. It is raised for badly framed characters as well.
- R5: When the stop-bit sample is 0, `frame_err_o` is 1. When it is 1, `frame_err_o` is 0. `frame_err_o` and `break_o` change only in the cycle in which `valid_o` is high, and they hold their values until the next character.
- R6: `break_o` is 1 exactly when the character is badly framed and all eight data bits are 0.
- R7: If the line is high again at the start-bit sample, no character is reported and the receiver returns to idle. It then accepts the next start edge.
- R8: Characters sent back to back with a single stop bit are all received, at any byte value.
- R9: After reset, `data_o` is 0 and `valid_o`, `frame_err_o` and `break_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| clks_per_bit_i | input | CPB_W | Bit period in clock cycles (at least 4) |
| lat_comp_i | input | COMP_W | Cycles taken off the half-bit delay to the first sample |
| data_o | output | DATA_W | Last received byte, LSB first on the line |
| valid_o | output | 1 | One-cycle strobe for a new character |
| frame_err_o | output | 1 | Stop bit of the last character was 0 |
| break_o | output | 1 | Last character was badly framed with all-zero data |

## Verification
All 256 byte values are sent back to back with one stop bit. This is done at an even bit period with compensation and again at an odd period without it. It shows that bit order, sample spacing and the return to idle all keep pace with the line. The delay from start edge to strobe is measured at three compensation values, one of them large enough to hit the floor of one cycle. This separates the half-bit arithmetic from the fixed pipeline latency. Characters with a low stop bit are sent with zero and non-zero data, which separates a framing error from a break. A short low pulse followed by a clean byte shows that noise is dropped and that the receiver recovers.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // Cycles from the detected start edge to the start-bit sample.
  function automatic int unsigned first_sample_delay(int unsigned cpb, int unsigned comp);
    int unsigned half;
    half = cpb >> 1;
    return (half > comp) ? (half - comp) : 32'd1;
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= line_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign line_o = s2_q;
  assign fall_o = s3_q & ~s2_q;
endmodule

// File: rtl/bit_timer.sv
module bit_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int DW = 8,
  localparam int NB_W = $clog2(DW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            shift_en_i,
  input  logic            bit_i,
  output logic [DW-1:0]   data_o,
  output logic [NB_W-1:0] count_o
);
  logic [DW-1:0]   sr_q;
  logic [NB_W-1:0] n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      n_q  <= '0;
    end else if (clr_i) begin
      sr_q <= '0;
      n_q  <= '0;
    end else if (shift_en_i) begin
      sr_q <= {bit_i, sr_q[DW-1:1]};
      n_q  <= n_q + 1'b1;
    end
  end

  assign data_o  = sr_q;
  assign count_o = n_q;
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CPB_W  = 16,
  parameter int COMP_W = 4,
  localparam int NB_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic [CPB_W-1:0]  clks_per_bit_i,
  input  logic [COMP_W-1:0] lat_comp_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              frame_err_o,
  output logic              break_o
);
  rx_state_e st_q, st_d;

  logic              line_w, fall_w, tick_w;
  logic              tmr_load_w;
  logic [CPB_W-1:0]  tmr_val_w, half_w;
  logic              shf_clr_w, shf_en_w;
  logic [DATA_W-1:0] shf_data_w;
  logic [NB_W-1:0]   shf_cnt_w;
  logic              glitch_w, stop_smp_w;

  logic [DATA_W-1:0] data_q;
  logic              valid_q, fe_q, brk_q;

  rx_sync u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(rx_i), .line_o(line_w), .fall_o(fall_w)
  );

  bit_timer #(.CW(CPB_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load_w), .load_val_i(tmr_val_w), .tick_o(tick_w)
  );

  rx_shifter #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr_i(shf_clr_w), .shift_en_i(shf_en_w),
    .bit_i(line_w), .data_o(shf_data_w), .count_o(shf_cnt_w)
  );

  assign half_w = CPB_W'(first_sample_delay(32'(clks_per_bit_i), 32'(lat_comp_i)));

  assign glitch_w   = (st_q == RX_START) && tick_w && line_w;
  assign stop_smp_w = (st_q == RX_STOP) && tick_w;

  always_comb begin
    st_d       = st_q;
    tmr_load_w = 1'b0;
    tmr_val_w  = clks_per_bit_i - 1'b1;
    shf_clr_w  = 1'b0;
    shf_en_w   = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        if (fall_w) begin
          st_d       = RX_START;
          tmr_load_w = 1'b1;
          tmr_val_w  = half_w - 1'b1;
          shf_clr_w  = 1'b1;
        end
      end
      RX_START: begin
        if (tick_w) begin
          if (line_w) begin
            st_d = RX_IDLE;
          end else begin
            st_d       = RX_DATA;
            tmr_load_w = 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick_w) begin
          shf_en_w   = 1'b1;
          tmr_load_w = 1'b1;
          if (shf_cnt_w == NB_W'(DATA_W - 1)) st_d = RX_STOP;
        end
      end
      RX_STOP: begin
        if (tick_w) st_d = RX_IDLE;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      data_q  <= '0;
      valid_q <= 1'b0;
      fe_q    <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      valid_q <= stop_smp_w;
      if (stop_smp_w) begin
        data_q <= shf_data_w;
        fe_q   <= ~line_w;
        brk_q  <= ~line_w && (shf_data_w == '0);
      end
    end
  end

  assign data_o      = data_q;
  assign valid_o     = valid_q;
  assign frame_err_o = fe_q;
  assign break_o     = brk_q;

  p_start_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_IDLE && fall_w) |=> (st_q == RX_START));

  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((fe_q != $past(fe_q)) || (brk_q != $past(brk_q))) |-> valid_q);

  p_break_framed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_q |-> (fe_q && data_q == '0));

  p_glitch_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_w |=> (st_q == RX_IDLE && !valid_q));

  p_ready_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (st_q == RX_IDLE));
endmodule

// File: tb/uart_rx_brk_tb.sv
module uart_rx_brk_tb;
  localparam int CLK_P = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic [15:0] cpb = 16'd16;
  logic [3:0]  comp = 4'd4;
  logic [7:0]  data_o;
  logic        valid_o, frame_err_o, break_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] got_d [0:1023];
  logic       got_fe [0:1023];
  logic       got_brk [0:1023];
  int         n_got = 0;
  int         wide_pulses = 0;
  logic       v_prev = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  uart_rx_brk u_dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .clks_per_bit_i(cpb), .lat_comp_i(comp),
    .data_o(data_o), .valid_o(valid_o), .frame_err_o(frame_err_o), .break_o(break_o)
  );

  always @(negedge clk) begin
    if (valid_o) begin
      got_d[n_got]   <= data_o;
      got_fe[n_got]  <= frame_err_o;
      got_brk[n_got] <= break_o;
      n_got <= n_got + 1;
    end
    if (valid_o && v_prev) wide_pulses <= wide_pulses + 1;
    v_prev <= valid_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic v);
    rx = v;
    repeat (int'(cpb)) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop_v);
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(b[i]);
    bit_out(stop_v);
  endtask

  task automatic idle(input int bits);
    rx = 1'b1;
    repeat (bits * int'(cpb)) @(negedge clk);
  endtask

  function automatic int exp_latency(input int p, input int c);
    int d;
    d = p / 2 - c;
    if (d < 1) d = 1;
    return d + 2 + 9 * p;
  endfunction

  task automatic latency_case(input int p, input int c, input logic [7:0] b);
    int lat;
    int base;
    cpb = 16'(p);
    comp = 4'(c);
    idle(2);
    base = n_got;
    fork
      send(b, 1'b1);
    join_none
    lat = 0;
    while (!valid_o && lat < 4000) begin
      @(negedge clk);
      lat++;
    end
    wait fork;
    // lat counts posedges from the falling input, one more than R2's count
    check(lat - 1 == exp_latency(p, c), "R2 latency", lat - 1, exp_latency(p, c));
    idle(2);
    check(n_got - base == 1, "R1 one character", n_got - base, 1);
    check(got_d[base] == b, "R3 data", int'(got_d[base]), int'(b));
  endtask

  task automatic sweep(input int p, input int c);
    int base;
    int bad;
    cpb = 16'(p);
    comp = 4'(c);
    idle(2);
    base = n_got;
    for (int v = 0; v < 256; v++) send(8'(v), 1'b1);
    idle(3);
    check(n_got - base == 256, "R8 back-to-back count", n_got - base, 256);
    bad = 0;
    for (int v = 0; v < 256; v++) begin
      check(got_d[base + v] == 8'(v), "R8 R3 sweep data", int'(got_d[base + v]), v);
      if (got_fe[base + v] || got_brk[base + v]) bad++;
    end
    check(bad == 0, "R5 no false framing error", bad, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(data_o == 8'd0, "R9 data_o", int'(data_o), 0);
    check({valid_o, frame_err_o, break_o} == 3'b000, "R9 flags", int'({valid_o, frame_err_o, break_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({valid_o, frame_err_o, break_o} == 3'b000, "R9 idle after reset", int'({valid_o, frame_err_o, break_o}), 0);

    // R2 timing with three compensation values
    latency_case(16, 4, 8'h3C);
    latency_case(16, 0, 8'hC3);
    latency_case(16, 12, 8'h81);

    // R8 full sweeps
    sweep(16, 4);
    sweep(7, 0);

    // R5 / R6 framing and break
    cpb = 16'd16;
    comp = 4'd4;
    idle(2);
    base = n_got;
    send(8'hA5, 1'b0); idle(2);
    check(frame_err_o == 1'b1 && break_o == 1'b0, "R5 framing error nonzero", int'({frame_err_o, break_o}), 2);
    check(got_d[base] == 8'hA5, "R4 valid with framing error", int'(got_d[base]), 8'hA5);
    send(8'h00, 1'b0); idle(2);
    check(break_o == 1'b1 && frame_err_o == 1'b1, "R6 break", int'({frame_err_o, break_o}), 3);
    idle(3);
    check(break_o == 1'b1, "R5 break held", int'(break_o), 1);
    send(8'h80, 1'b0); idle(2);
    check(frame_err_o == 1'b1 && break_o == 1'b0, "R6 no break with data", int'({frame_err_o, break_o}), 2);
    send(8'h00, 1'b1); idle(2);
    check(frame_err_o == 1'b0 && break_o == 1'b0, "R5 good zero byte", int'({frame_err_o, break_o}), 0);
    check(n_got - base == 4, "R4 strobes", n_got - base, 4);

    // R7 glitch
    base = n_got;
    rx = 1'b0;
    repeat (3) @(negedge clk);
    rx = 1'b1;
    idle(3);
    check(n_got - base == 0, "R7 glitch dropped", n_got - base, 0);
    send(8'h5A, 1'b1); idle(2);
    check(n_got - base == 1 && got_d[base] == 8'h5A, "R7 recovery", int'(got_d[base]), 8'h5A);

    check(wide_pulses == 0, "R4 single-cycle strobe", wide_pulses, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule